// File: doc/BRIEF.md
# Pulse Shape Discrimination Engine

This block sits behind the digitizer of one scintillator channel. It takes signed 16-bit samples over a valid/ready stream, one record at a time, and stores them in a local buffer. While it fills the buffer it watches for the first sample at or above a programmable threshold and keeps that trigger index. Every later step reads only the buffer slices that the trigger index selects.

Once the record is complete, the engine stalls its input. It reads a quiet stretch of 2^L samples that ends a guard gap before the trigger and takes the mean and variance of that stretch. It then walks a window of programmable width that starts at the trigger. Over that window it finds the peak of the baseline-subtracted signal and its index, and it sums a short integral over the head of the pulse and a long integral over the whole window. The particle type comes from a divider-free comparison of the two integrals against a programmable cut. The engine emits one result beat and then accepts the next record.

Top module: `psd_engine`

## Requirements
- R1: A record starts with an accepted sample that has `in_sof` high while the engine awaits a record, and holds `cfg_rec_len` accepted samples. Accepted samples without `in_sof` while it awaits a record are discarded and do not affect any result.
- R2: The trigger index is the first record index whose sample, taken as signed, is greater than or equal to `cfg_thresh`. If no sample qualifies, the result has status 1 and all numeric fields and the neutron flag are zero.
- R3: With N = 2^`cfg_bl_log2`, the baseline stretch is indices trigger−guard−N to trigger−guard−1. If the trigger index is below guard+N, the result has status 2 and all numeric fields and the neutron flag are zero.
- R4: The baseline mean is floor(sum/N), computed as an arithmetic shift. The variance is floor(sum of squares/N) − mean², in signed form.
- R5: The analysis window runs from the trigger index to min(trigger+`cfg_pw`, `cfg_rec_len`)−1. Samples after the window do not affect any result.
- R6: The amplitude is the largest value of sample−mean in the window. The pulse time is the record index of the first sample that reaches that value.
- R7: The long integral is the sum of sample−mean over the window. The short integral is the same sum over window offsets below `cfg_short`.
- R8: With status 0, the neutron flag is 1 exactly when short×2^K < `cfg_cut`×long, where K is the parameter K_SHIFT. With any other status the flag is 0.
- R9: `in_ready` is low from the cycle after the last sample of a record is accepted, through the cycle in which `out_valid` is high. `out_valid` lasts one cycle per record.
- R10: Each record yields exactly one result. A record that starts in the cycle after `in_ready` returns is captured in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Engine accepts a sample |
| in_sof | input | 1 | Sample is the first of a record |
| in_data | input | DW | Signed sample |
| cfg_rec_len | input | IDX_W+1 | Samples per record (1..MAX_LEN) |
| cfg_thresh | input | DW | Signed trigger level |
| cfg_bl_log2 | input | 3 | Log2 of baseline stretch length |
| cfg_guard | input | IDX_W | Gap between baseline stretch and trigger |
| cfg_pw | input | IDX_W+1 | Window width in samples (at least 1) |
| cfg_short | input | IDX_W+1 | Length of short integration range |
| cfg_cut | input | 16 | Unsigned ratio cut, scaled by 2^K |
| out_valid | output | 1 | Result beat |
| out_status | output | 2 | 0 event, 1 no trigger, 2 short pre-trigger |
| out_neutron | output | 1 | Event classified as neutron |
| out_time | output | IDX_W | Index of the peak |
| out_amp | output | DW+1 | Signed peak above baseline |
| out_qshort | output | ACC_W | Signed short integral |
| out_qlong | output | ACC_W | Signed long integral |
| out_bl_mean | output | DW | Signed baseline mean |
| out_bl_var | output | SQ_W | Signed baseline variance |

## Verification
The hardest conditions to reach from the ports are the edges of the index arithmetic. These include a trigger that sits exactly at guard+N, a window cut short by the end of the record, and a trigger on a sample equal to the threshold. A sweep over pulse position, decay rate, baseline length, guard gap and window width reaches each of them, and dedicated records place these cases at the exact boundary. Spikes placed past the window and out-of-record samples sent ahead of each start marker show that those samples are ignored. Each record is offered as soon as `in_ready` returns, so back-to-back capture is exercised on every record.

// File: rtl/psd_pkg.sv
package psd_pkg;

  typedef enum logic [1:0] {
    ST_EVENT   = 2'd0,
    ST_NOTRIG  = 2'd1,
    ST_SHORTPRE = 2'd2
  } psd_status_e;

  typedef enum logic [1:0] {CP_WAIT, CP_FILL, CP_HOLD} cap_mode_e;

  typedef enum logic [2:0] {AN_IDLE, AN_BASE, AN_MEAN, AN_WIN, AN_OUT} an_state_e;

  // floor(sum / 2^l) by arithmetic shift
  function automatic logic signed [63:0] floor_mean(input logic signed [63:0] sum,
                                                    input logic [2:0] l);
    return sum >>> l;
  endfunction

  // floor(sumsq / 2^l) - mean^2
  function automatic logic signed [63:0] spread(input logic signed [63:0] sumsq,
                                                input logic signed [63:0] mean,
                                                input logic [2:0] l);
    return (sumsq >>> l) - mean * mean;
  endfunction

  // divider-free ratio test: short * 2^k < cut * long
  function automatic logic is_neutron(input logic signed [63:0] qs,
                                      input logic signed [63:0] ql,
                                      input logic [15:0] cut,
                                      input int unsigned k);
    logic signed [63:0] lhs, rhs;
    lhs = qs <<< k;
    rhs = $signed({48'd0, cut}) * ql;
    return lhs < rhs;
  endfunction

endpackage

// File: rtl/psd_capture.sv
module psd_capture
  import psd_pkg::*;
#(
  parameter int DW      = 16,
  parameter int MAX_LEN = 256,
  parameter int IDX_W   = $clog2(MAX_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic signed [DW-1:0] in_data,
  output logic                 in_ready,
  input  logic [IDX_W:0]       rec_len,
  input  logic signed [DW-1:0] thresh,
  input  logic                 rel_i,
  output logic                 done,
  output logic                 found,
  output logic [IDX_W-1:0]     tidx,
  output logic [IDX_W:0]       len_q,
  input  logic [IDX_W-1:0]     rd_addr,
  output logic signed [DW-1:0] rd_data
);

  cap_mode_e           mode;
  logic [IDX_W:0]      cnt;
  logic signed [DW-1:0] mem [MAX_LEN];
  logic                acc, hit, wr_en;
  logic [IDX_W-1:0]    wr_idx;

  assign in_ready = (mode != CP_HOLD);
  assign acc      = in_valid && in_ready;
  assign hit      = (in_data >= thresh);
  assign wr_en    = acc && ((mode == CP_FILL) || (mode == CP_WAIT && in_sof));
  assign wr_idx   = (mode == CP_WAIT) ? '0 : cnt[IDX_W-1:0];
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= CP_WAIT;
      cnt   <= '0;
      found <= 1'b0;
      tidx  <= '0;
      len_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (mode)
        CP_WAIT: if (acc && in_sof) begin
          cnt   <= (IDX_W+1)'(1);
          len_q <= rec_len;
          found <= hit;
          tidx  <= '0;
          if (rec_len <= (IDX_W+1)'(1)) begin
            mode <= CP_HOLD;
            done <= 1'b1;
          end else begin
            mode <= CP_FILL;
          end
        end
        CP_FILL: if (acc) begin
          cnt <= cnt + 1'b1;
          if (!found && hit) begin
            found <= 1'b1;
            tidx  <= cnt[IDX_W-1:0];
          end
          if (cnt + 1'b1 == len_q) begin
            mode <= CP_HOLD;
            done <= 1'b1;
          end
        end
        default: if (rel_i) mode <= CP_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/psd_analyze.sv
module psd_analyze
  import psd_pkg::*;
#(
  parameter int DW      = 16,
  parameter int IDX_W   = 8,
  parameter int ACC_W   = 40,
  parameter int SQ_W    = 48,
  parameter int K_SHIFT = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    trig_found,
  input  logic [IDX_W-1:0]        trig_idx,
  input  logic [IDX_W:0]          rec_len,
  input  logic [2:0]              bl_log2,
  input  logic [IDX_W-1:0]        guard,
  input  logic [IDX_W:0]          pw,
  input  logic [IDX_W:0]          short_len,
  input  logic [15:0]             cut,
  input  logic signed [DW-1:0]    rd_data,
  output logic [IDX_W-1:0]        rd_addr,
  output logic                    res_valid,
  output logic [1:0]              status,
  output logic                    neutron,
  output logic [IDX_W-1:0]        ptime,
  output logic signed [DW:0]      amp,
  output logic signed [ACC_W-1:0] qshort,
  output logic signed [ACC_W-1:0] qlong,
  output logic signed [DW-1:0]    mean,
  output logic signed [SQ_W-1:0]  bvar,
  output logic [IDX_W+1:0]        win_end
);

  localparam int CW = IDX_W + 9;

  an_state_e              state;
  logic [CW-1:0]          ptr, trig_w, nbase, base_need, base_lo, base_hi, tp, wend_w, offs;
  logic signed [ACC_W-1:0] sum;
  logic signed [SQ_W-1:0]  sumsq;
  logic signed [DW:0]     d;
  logic signed [2*DW-1:0] sq;
  logic signed [63:0]     mean64;
  logic                   first;

  assign trig_w    = CW'(trig_idx);
  assign nbase     = CW'(1) << bl_log2;
  assign base_need = CW'(guard) + nbase;
  assign base_lo   = trig_w - base_need;
  assign base_hi   = trig_w - CW'(guard) - CW'(1);
  assign tp        = trig_w + CW'(pw);
  assign wend_w    = (tp < CW'(rec_len)) ? tp : CW'(rec_len);
  assign win_end   = (IDX_W+2)'(wend_w);
  assign offs      = ptr - trig_w;
  assign rd_addr   = ptr[IDX_W-1:0];
  assign d         = (DW+1)'(rd_data) - (DW+1)'(mean);
  assign sq        = rd_data * rd_data;
  assign mean64    = floor_mean(64'(sum), bl_log2);
  assign res_valid = (state == AN_OUT);
  assign neutron   = (status == ST_EVENT) &&
                     is_neutron(64'(qshort), 64'(qlong), cut, K_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= AN_IDLE;
      ptr <= '0; sum <= '0; sumsq <= '0; first <= 1'b0;
      status <= ST_EVENT; ptime <= '0; amp <= '0;
      qshort <= '0; qlong <= '0; mean <= '0; bvar <= '0;
    end else begin
      case (state)
        AN_IDLE: if (start) begin
          sum <= '0; sumsq <= '0; first <= 1'b1;
          ptime <= '0; amp <= '0; qshort <= '0; qlong <= '0;
          mean <= '0; bvar <= '0;
          if (!trig_found) begin
            status <= ST_NOTRIG;
            state  <= AN_OUT;
          end else if (trig_w < base_need) begin
            status <= ST_SHORTPRE;
            state  <= AN_OUT;
          end else begin
            status <= ST_EVENT;
            ptr    <= base_lo;
            state  <= AN_BASE;
          end
        end
        AN_BASE: begin
          sum   <= sum + ACC_W'(rd_data);
          sumsq <= sumsq + SQ_W'(sq);
          if (ptr == base_hi) state <= AN_MEAN;
          else ptr <= ptr + CW'(1);
        end
        AN_MEAN: begin
          mean  <= DW'(mean64);
          bvar  <= SQ_W'(spread(64'(sumsq), mean64, bl_log2));
          ptr   <= trig_w;
          state <= AN_WIN;
        end
        AN_WIN: begin
          qlong <= qlong + ACC_W'(d);
          if (offs < CW'(short_len)) qshort <= qshort + ACC_W'(d);
          if (first || d > amp) begin
            amp   <= d;
            ptime <= ptr[IDX_W-1:0];
          end
          first <= 1'b0;
          if (ptr + CW'(1) == wend_w) state <= AN_OUT;
          else ptr <= ptr + CW'(1);
        end
        default: state <= AN_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/psd_engine.sv
module psd_engine
  import psd_pkg::*;
#(
  parameter int DW      = 16,
  parameter int MAX_LEN = 256,
  parameter int ACC_W   = 40,
  parameter int SQ_W    = 48,
  parameter int K_SHIFT = 8,
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sof,
  input  logic signed [DW-1:0]    in_data,
  input  logic [IDX_W:0]          cfg_rec_len,
  input  logic signed [DW-1:0]    cfg_thresh,
  input  logic [2:0]              cfg_bl_log2,
  input  logic [IDX_W-1:0]        cfg_guard,
  input  logic [IDX_W:0]          cfg_pw,
  input  logic [IDX_W:0]          cfg_short,
  input  logic [15:0]             cfg_cut,
  output logic                    out_valid,
  output logic [1:0]              out_status,
  output logic                    out_neutron,
  output logic [IDX_W-1:0]        out_time,
  output logic signed [DW:0]      out_amp,
  output logic signed [ACC_W-1:0] out_qshort,
  output logic signed [ACC_W-1:0] out_qlong,
  output logic signed [DW-1:0]    out_bl_mean,
  output logic signed [SQ_W-1:0]  out_bl_var
);

  // named internal events for the checker
  logic                 cap_done;
  logic                 trig_found;
  logic [IDX_W-1:0]     trig_idx;
  logic [IDX_W:0]       rec_len_q;
  logic [IDX_W-1:0]     rd_addr;
  logic signed [DW-1:0] rd_data;
  logic [IDX_W+1:0]     win_end;

  psd_capture #(.DW(DW), .MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data), .in_ready(in_ready),
    .rec_len(cfg_rec_len), .thresh(cfg_thresh), .rel_i(out_valid),
    .done(cap_done), .found(trig_found), .tidx(trig_idx), .len_q(rec_len_q),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  psd_analyze #(.DW(DW), .IDX_W(IDX_W), .ACC_W(ACC_W), .SQ_W(SQ_W), .K_SHIFT(K_SHIFT)) u_an (
    .clk(clk), .rst_n(rst_n), .start(cap_done),
    .trig_found(trig_found), .trig_idx(trig_idx), .rec_len(rec_len_q),
    .bl_log2(cfg_bl_log2), .guard(cfg_guard), .pw(cfg_pw), .short_len(cfg_short),
    .cut(cfg_cut), .rd_data(rd_data), .rd_addr(rd_addr),
    .res_valid(out_valid), .status(out_status), .neutron(out_neutron),
    .ptime(out_time), .amp(out_amp), .qshort(out_qshort), .qlong(out_qlong),
    .mean(out_bl_mean), .bvar(out_bl_var), .win_end(win_end)
  );

endmodule

// File: rtl/psd_engine_chk.sv
module psd_engine_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic [1:0]       out_status,
  input logic             out_neutron,
  input logic [IDX_W-1:0] out_time,
  input logic             cap_done,
  input logic             trig_found,
  input logic [IDX_W-1:0] trig_idx,
  input logic [IDX_W+1:0] win_end
);

  p_stall_on_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_single_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_stall_after_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> !in_ready);

  p_neutron_needs_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status != 2'd0) |-> !out_neutron);

  p_notrig_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !trig_found) |-> out_status == 2'd1);

  p_time_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == 2'd0) |->
      (out_time >= trig_idx && (IDX_W+2)'(out_time) < win_end));

  p_result_after_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> !out_valid);

endmodule

bind psd_engine psd_engine_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_status(out_status), .out_neutron(out_neutron), .out_time(out_time),
  .cap_done(cap_done), .trig_found(trig_found), .trig_idx(trig_idx),
  .win_end(win_end)
);

// File: tb/psd_engine_test.sv
module psd_engine_test;

  localparam int DW = 16, MAX_LEN = 64, IDX_W = 6, ACC_W = 40, SQ_W = 48, KS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic in_valid = 1'b0, in_sof = 1'b0, in_ready;
  logic signed [DW-1:0] in_data = '0;
  logic [IDX_W:0] cfg_rec_len = 7'd64, cfg_pw = 7'd8, cfg_short = 7'd3;
  logic signed [DW-1:0] cfg_thresh = 16'sd1000;
  logic [2:0] cfg_bl_log2 = 3'd2;
  logic [IDX_W-1:0] cfg_guard = 6'd1;
  logic [15:0] cfg_cut = 16'd12;
  logic out_valid, out_neutron;
  logic [1:0] out_status;
  logic [IDX_W-1:0] out_time;
  logic signed [DW:0] out_amp;
  logic signed [ACC_W-1:0] out_qshort, out_qlong;
  logic signed [DW-1:0] out_bl_mean;
  logic signed [SQ_W-1:0] out_bl_var;

  psd_engine #(.DW(DW), .MAX_LEN(MAX_LEN), .ACC_W(ACC_W), .SQ_W(SQ_W), .K_SHIFT(KS)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
    .in_data(in_data), .cfg_rec_len(cfg_rec_len), .cfg_thresh(cfg_thresh),
    .cfg_bl_log2(cfg_bl_log2), .cfg_guard(cfg_guard), .cfg_pw(cfg_pw), .cfg_short(cfg_short),
    .cfg_cut(cfg_cut), .out_valid(out_valid), .out_status(out_status),
    .out_neutron(out_neutron), .out_time(out_time), .out_amp(out_amp),
    .out_qshort(out_qshort), .out_qlong(out_qlong), .out_bl_mean(out_bl_mean),
    .out_bl_var(out_bl_var)
  );

  typedef struct {longint st, tm, amp, qs, ql, mn, vr, nt;} exp_t;
  exp_t expq[$];
  int total = 0, bad = 0, sent = 0, got = 0;
  logic finished = 1'b0;
  int unsigned seed = 32'd7;
  longint rec[64];

  task automatic chk(input string what, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int noise();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 5) - 2;
  endfunction

  // reference model, written from the requirements
  function automatic exp_t model(input int len, input longint thr, input int l,
                                 input int guard, input int pw, input int sh, input longint cut);
    exp_t e;
    int trig, n, wend;
    longint s, s2;
    e = '{default: 0};
    trig = -1;
    for (int i = 0; i < len; i++) if (trig < 0 && rec[i] >= thr) trig = i;
    n = 1 << l;
    if (trig < 0) begin e.st = 1; return e; end
    if (trig < guard + n) begin e.st = 2; return e; end
    s = 0; s2 = 0;
    for (int i = trig - guard - n; i < trig - guard; i++) begin
      s += rec[i]; s2 += rec[i] * rec[i];
    end
    e.mn = (s - (((s % n) + n) % n)) / n;
    e.vr = s2 / n - e.mn * e.mn;
    wend = (trig + pw < len) ? trig + pw : len;
    for (int i = trig; i < wend; i++) begin
      longint dv;
      dv = rec[i] - e.mn;
      e.ql += dv;
      if (i - trig < sh) e.qs += dv;
      if (i == trig || dv > e.amp) begin e.amp = dv; e.tm = i; end
    end
    e.nt = (e.qs * (1 << KS) < cut * e.ql) ? 1 : 0;
    return e;
  endfunction

  // fill rec with baseline b plus a decaying pulse at pos (pos<0: none)
  task automatic make(input int len, input int pos, input int tail, input longint b);
    for (int i = 0; i < len; i++) begin
      rec[i] = b + noise();
      if (pos >= 0 && i >= pos) begin
        int sh;
        sh = (i - pos) / tail;
        if (sh < 15) rec[i] += 2000 >>> sh;
      end
    end
  endtask

  task automatic send(input int len, input int l, input int guard, input int pw,
                      input int sh, input int garbage);
    exp_t e;
    while (!in_ready) @(negedge clk);
    cfg_rec_len = 7'(len); cfg_bl_log2 = 3'(l); cfg_guard = 6'(guard);
    cfg_pw = 7'(pw); cfg_short = 7'(sh);
    e = model(len, longint'(cfg_thresh), l, guard, pw, sh, longint'(cfg_cut));
    expq.push_back(e);
    sent++;
    // R1: samples without start marker before the record are dropped
    for (int g = 0; g < garbage; g++) begin
      in_valid = 1'b1; in_sof = 1'b0; in_data = 16'sd30000;
      @(negedge clk);
    end
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_sof = (i == 0); in_data = 16'(rec[i]);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0;
    chk("R9 ready low after record", longint'(in_ready), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      exp_t e;
      got++;
      if (expq.size() == 0) begin
        chk("R10 unexpected result", 1, 0);
      end else begin
        e = expq.pop_front();
        chk("R2/R3 status", longint'(out_status), e.st);
        chk("R6 time", longint'(out_time), e.tm);
        chk("R6 amp", longint'(out_amp), e.amp);
        chk("R7 qshort", longint'(out_qshort), e.qs);
        chk("R7 qlong", longint'(out_qlong), e.ql);
        chk("R4 mean", longint'(out_bl_mean), e.mn);
        chk("R4 var", longint'(out_bl_var), e.vr);
        chk("R8 neutron", longint'(out_neutron), e.nt);
        chk("R9 ready low with result", longint'(in_ready), 0);
      end
    end
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    longint b;
    repeat (3) @(negedge clk);
    chk("R9 reset ready", longint'(in_ready), 1);
    chk("R9 reset out_valid", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: R2 R3 R4 R5 R6 R7 R8 R10
    foreach (rec[k]) rec[k] = 0;
    for (int p = 0; p < 3; p++)
      for (int t = 1; t <= 4; t += 3)
        for (int l = 1; l <= 3; l++)
          for (int g = 0; g <= 2; g += 2)
            for (int w = 0; w < 2; w++) begin
              b = ((p + l) % 2 == 0) ? -300 : 100;
              cfg_thresh = 16'(b + 1000);
              make(64, 12 + 14 * p, t, b);
              send(64, l, g, w ? 16 : 6, w ? 5 : 3, (p == 1) ? 3 : 0);
            end

    // R2: no crossing
    cfg_thresh = 16'sd1100; make(64, -1, 1, 100); send(64, 2, 1, 8, 3, 0);
    // R3: too few pre-trigger samples
    make(64, 3, 2, 100); send(64, 2, 1, 8, 3, 0);
    // R3: trigger exactly at guard+N
    make(64, 6, 2, 100); send(64, 2, 2, 8, 3, 0);
    // R5: window clipped by record end
    make(64, 58, 4, 100); send(64, 2, 1, 16, 4, 0);
    // R5: spike past the window is ignored
    make(64, 20, 1, 100); rec[40] = 6000; send(64, 2, 1, 8, 3, 0);
    // R2: sample equal to threshold triggers
    make(40, -1, 1, 100); rec[20] = 1100; rec[21] = 1500; send(40, 3, 0, 4, 2, 0);
    // R7: short range longer than window
    make(64, 30, 4, 100); send(64, 3, 2, 6, 20, 2);
    // R1: short record, back-to-back
    make(32, 16, 1, -300); cfg_thresh = -16'sd100; send(32, 1, 1, 5, 2, 1);

    while (expq.size() != 0) @(negedge clk);
    chk("R10 one result per record", longint'(got), longint'(sent));
    finish_up();
  end

endmodule